// File: doc/BRIEF.md
# Fixed-Point Multiply-Accumulate Unit with Dual 80-bit Accumulators

The unit multiplies two 32-bit fixed-point operands and combines the product with one of two 80-bit accumulators: a foreground bank and a background bank. Every instruction names one bank. Each instruction also chooses how the operands are read. Each operand can be signed or unsigned, and the pair can be integer or fractional. In fractional mode the product is moved one place to the left, so that it does not carry a second sign bit.

Each accumulator is handled as three slices:

- a 16-bit guard slice (bits 79:64),
- a 32-bit high word (bits 63:32),
- a 32-bit low word (bits 31:0).

Any slice can be copied to the 32-bit result port or loaded from operand A.

The unit can also:

- saturate the accumulator to the range of the current format,
- round it to its high word,
- send a product straight to the result port without touching any accumulator.

Arithmetic instructions update three status bits: negative, overflow and underflow. An overflow also sets a sticky bit, which stays set until reset. All state changes on the rising clock edge that samples the instruction.

Top module: `mac80_unit`

## Requirements
- R1: Reset is asynchronous and active low. It clears both accumulators, `result`, `stat` and `sticky`.
- R2: The `fmt` input selects the operand formats:
  - `fmt[0]=1` reads `opa` as signed.
  - `fmt[1]=1` reads `opb` as signed.
  - `fmt[2]=1` selects fractional mode.

  The MUL instruction (code 2) loads the selected accumulator with the exact product, sign-extended to 80 bits.
- R3: In fractional mode the product is shifted left by one bit before it is used. The RDR instruction (code 14) returns the high word in fractional mode and the low word in integer mode.
- R4: Accumulate instructions wrap modulo 2^80:
  - MAC (code 3) adds the product to the selected accumulator.
  - MSB (code 4) subtracts the product from it.
  - CLR (code 1) zeroes it.
- R5: Input `bank` selects the target: 0 is the foreground accumulator and 1 is the background accumulator. An instruction never changes the accumulator that it does not select.
- R6: Slice reads return the selected accumulator's slice on `result`:
  - RD2 (code 8) returns the guard slice, sign-extended.
  - RD1 (code 9) returns the high word.
  - RD0 (code 10) returns the low word.

  Slice writes load one slice from `opa` and leave the other slices unchanged:
  - WR2 (code 11) loads the guard slice from `opa[15:0]`.
  - WR1 (code 12) loads the high word.
  - WR0 (code 13) loads the low word.
- R7: MULR (code 5) places the product on `result` and leaves both accumulators unchanged. In integer mode it places product bits 31:0; in fractional mode it places bits 63:32 of the shifted product.
- R8: SAT (code 6) clamps an out-of-range accumulator to the most positive or most negative value of the current range, as chosen by the accumulator's sign. The range is 32-bit signed in integer mode and 64-bit signed in fractional mode. An in-range accumulator is left unchanged.
- R9: RND (code 7) adds 2^31 to the accumulator and then clears bits 31:0.
- R10: After CLR, MUL, MAC, MSB, MULR, SAT or RND, `stat` holds three flags and all its other bits are 0:
  - Bit 6 is the sign of the value.
  - Bit 7 is set when the bits above the range are not all copies of the sign bit. In integer mode these are bits 79:31; in fractional mode they are bits 79:63.
  - Bit 8 is set, in fractional mode only, for a nonzero value with no overflow whose bits 79:31 all equal the sign bit.

  The value is the product for MULR and the new accumulator for the other instructions.
- R11: `sticky` bit 6 is set whenever status bit 7 is set, and it stays set until reset. All other `sticky` bits are 0.
- R12: NOP (code 0), slice reads and slice writes leave `stat` and `sticky` unchanged. `result` changes only on MULR, RDR and slice reads.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op | input | 4 | Instruction code |
| opa | input | 32 | Operand A; data source for slice writes |
| opb | input | 32 | Operand B |
| fmt | input | 3 | Format: [0] A signed, [1] B signed, [2] fractional |
| bank | input | 1 | Accumulator select: 0 foreground, 1 background |
| result | output | 32 | Registered result word |
| stat | output | 16 | Status flags (bits 6, 7 and 8) |
| sticky | output | 16 | Sticky flags (bit 6) |

## Verification
Every instruction takes effect on the rising edge that samples it. The accumulators, `result`, `stat` and `sticky` all show the outcome one cycle after the instruction is driven.

The bench follows a fixed pattern for each instruction:
1. Apply the instruction on a falling edge.
2. Let exactly one rising edge sample it.
3. Compare all three outputs on the next falling edge.
4. Return the bus to NOP.

Accumulator contents are observed one instruction later, through slice reads. Reset is checked a short time after it is asserted, with no clock edge needed.

// File: rtl/mac_pkg.sv
package mac_pkg;
  typedef enum logic [3:0] {
    OP_NOP  = 4'd0,
    OP_CLR  = 4'd1,
    OP_MUL  = 4'd2,
    OP_MAC  = 4'd3,
    OP_MSB  = 4'd4,
    OP_MULR = 4'd5,
    OP_SAT  = 4'd6,
    OP_RND  = 4'd7,
    OP_RD2  = 4'd8,
    OP_RD1  = 4'd9,
    OP_RD0  = 4'd10,
    OP_WR2  = 4'd11,
    OP_WR1  = 4'd12,
    OP_WR0  = 4'd13,
    OP_RDR  = 4'd14
  } mac_op_e;

  localparam int STATW   = 16;
  localparam int FLG_NEG = 6;
  localparam int FLG_OVF = 7;
  localparam int FLG_UNF = 8;
  localparam int STK_OVF = 6;

  localparam int FMT_XS = 0;
  localparam int FMT_YS = 1;
  localparam int FMT_FR = 2;
endpackage

// File: rtl/mac_prod.sv
module mac_prod import mac_pkg::*; #(
  parameter int DW = 32,
  parameter int AW = 80
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic [2:0]    fmt_i,
  output logic [AW-1:0] prod_o
);
  localparam int PW = 2*DW + 2;

  logic signed [DW:0]   xa, xb;
  logic signed [PW-1:0] full;
  logic        [AW-1:0] ext;

  always_comb begin
    xa     = {fmt_i[FMT_XS] & a_i[DW-1], a_i};
    xb     = {fmt_i[FMT_YS] & b_i[DW-1], b_i};
    full   = xa * xb;
    ext    = {{(AW-PW){full[PW-1]}}, full};
    prod_o = fmt_i[FMT_FR] ? {ext[AW-2:0], 1'b0} : ext;
  end
endmodule

// File: rtl/mac_range.sv
module mac_range #(
  parameter int DW = 32,
  parameter int AW = 80
) (
  input  logic [AW-1:0] val_i,
  input  logic          frac_i,
  output logic          neg_o,
  output logic          ovf_o,
  output logic          unf_o
);
  localparam int HI_I = AW - DW + 1;
  localparam int HI_F = AW - 2*DW + 1;

  logic [HI_I-1:0] hi_i;
  logic [HI_F-1:0] hi_f;
  logic            uni_i, uni_f;

  always_comb begin
    hi_i  = val_i[AW-1:DW-1];
    hi_f  = val_i[AW-1:2*DW-1];
    uni_i = (&hi_i) | ~(|hi_i);
    uni_f = (&hi_f) | ~(|hi_f);
    neg_o = val_i[AW-1];
    ovf_o = frac_i ? ~uni_f : ~uni_i;
    unf_o = frac_i & (|val_i) & uni_i;
  end
endmodule

// File: rtl/mac_accnext.sv
module mac_accnext import mac_pkg::*; #(
  parameter int DW = 32,
  parameter int GW = 16,
  parameter int AW = 80
) (
  input  mac_op_e       op_i,
  input  logic [AW-1:0] acc_i,
  input  logic [AW-1:0] prod_i,
  input  logic [DW-1:0] a_i,
  input  logic          frac_i,
  output logic [AW-1:0] acc_o,
  output logic          we_o
);
  localparam logic [AW-1:0] IMAX = {{(AW-DW+1){1'b0}}, {(DW-1){1'b1}}};
  localparam logic [AW-1:0] FMAX = {{(AW-2*DW+1){1'b0}}, {(2*DW-1){1'b1}}};
  localparam logic [AW-1:0] HALF = AW'(1) << (DW-1);

  logic [AW-DW:0]   hi_i;
  logic [AW-2*DW:0] hi_f;
  logic             out_rng;
  logic [AW-1:0]    lim, rnd;

  always_comb begin
    hi_i    = acc_i[AW-1:DW-1];
    hi_f    = acc_i[AW-1:2*DW-1];
    out_rng = frac_i ? ~((&hi_f) | ~(|hi_f)) : ~((&hi_i) | ~(|hi_i));
    lim     = frac_i ? FMAX : IMAX;
    if (acc_i[AW-1]) lim = ~lim;
    rnd     = acc_i + HALF;
    acc_o   = acc_i;
    we_o    = 1'b1;
    case (op_i)
      OP_CLR:  acc_o = '0;
      OP_MUL:  acc_o = prod_i;
      OP_MAC:  acc_o = acc_i + prod_i;
      OP_MSB:  acc_o = acc_i - prod_i;
      OP_SAT:  acc_o = out_rng ? lim : acc_i;
      OP_RND:  acc_o = {rnd[AW-1:DW], {DW{1'b0}}};
      OP_WR2:  acc_o = {a_i[GW-1:0], acc_i[2*DW-1:0]};
      OP_WR1:  acc_o = {acc_i[AW-1:2*DW], a_i, acc_i[DW-1:0]};
      OP_WR0:  acc_o = {acc_i[AW-1:DW], a_i};
      default: we_o  = 1'b0;
    endcase
  end
endmodule

// File: rtl/mac80_unit.sv
module mac80_unit import mac_pkg::*; #(
  parameter int DW = 32,
  parameter int GW = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [3:0]       op,
  input  logic [DW-1:0]    opa,
  input  logic [DW-1:0]    opb,
  input  logic [2:0]       fmt,
  input  logic             bank,
  output logic [DW-1:0]    result,
  output logic [STATW-1:0] stat,
  output logic [STATW-1:0] sticky
);
  localparam int AW    = 2*DW + GW;
  localparam int NBANK = 2;

  logic [1:0]       rsync_q;
  logic             rst_ns;
  mac_op_e          op_e;
  logic [AW-1:0]    acc_q [NBANK];
  logic [AW-1:0]    cur, prod, acc_nx, flag_val;
  logic             acc_we, flag_en, res_en, frac;
  logic             f_neg, f_ovf, f_unf;
  logic [DW-1:0]    res_q, res_nx;
  logic [STATW-1:0] stat_q, stat_nx, stk_q, stk_nx;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  assign rst_ns = rsync_q[1];

  assign op_e = mac_op_e'(op);
  assign frac = fmt[FMT_FR];
  assign cur  = acc_q[bank];

  mac_prod #(.DW(DW), .AW(AW)) u_prod (
    .a_i(opa), .b_i(opb), .fmt_i(fmt), .prod_o(prod)
  );

  mac_accnext #(.DW(DW), .GW(GW), .AW(AW)) u_next (
    .op_i(op_e), .acc_i(cur), .prod_i(prod), .a_i(opa), .frac_i(frac),
    .acc_o(acc_nx), .we_o(acc_we)
  );

  assign flag_val = (op_e == OP_MULR) ? prod : acc_nx;

  mac_range #(.DW(DW), .AW(AW)) u_rng (
    .val_i(flag_val), .frac_i(frac), .neg_o(f_neg), .ovf_o(f_ovf), .unf_o(f_unf)
  );

  always_comb begin
    flag_en = (op_e inside {OP_CLR, OP_MUL, OP_MAC, OP_MSB, OP_MULR, OP_SAT, OP_RND});
    res_en  = 1'b1;
    case (op_e)
      OP_RD2:  res_nx = {{(DW-GW){cur[AW-1]}}, cur[AW-1:2*DW]};
      OP_RD1:  res_nx = cur[2*DW-1:DW];
      OP_RD0:  res_nx = cur[DW-1:0];
      OP_RDR:  res_nx = frac ? cur[2*DW-1:DW] : cur[DW-1:0];
      OP_MULR: res_nx = frac ? prod[2*DW-1:DW] : prod[DW-1:0];
      default: begin res_nx = res_q; res_en = 1'b0; end
    endcase
    stat_nx          = '0;
    stat_nx[FLG_NEG] = f_neg;
    stat_nx[FLG_OVF] = f_ovf;
    stat_nx[FLG_UNF] = f_unf;
    stk_nx           = stk_q;
    stk_nx[STK_OVF]  = stk_q[STK_OVF] | f_ovf;
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      for (int i = 0; i < NBANK; i++) acc_q[i] <= '0;
      res_q  <= '0;
      stat_q <= '0;
      stk_q  <= '0;
    end else begin
      for (int i = 0; i < NBANK; i++)
        if (acc_we && (int'(bank) == i)) acc_q[i] <= acc_nx;
      if (res_en)  res_q  <= res_nx;
      if (flag_en) stat_q <= stat_nx;
      if (flag_en) stk_q  <= stk_nx;
    end
  end

  assign result = res_q;
  assign stat   = stat_q;
  assign sticky = stk_q;
endmodule

// File: rtl/mac80_chk.sv
module mac80_chk import mac_pkg::*; #(
  parameter int DW = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic [3:0]       op,
  input logic [DW-1:0]    result,
  input logic [STATW-1:0] stat,
  input logic [STATW-1:0] sticky
);
  logic quiet, holds_res;
  assign quiet     = (op == OP_NOP) || (op >= OP_RD2);
  assign holds_res = (op <= OP_MSB) || (op == OP_SAT) || (op == OP_RND) ||
                     (op == OP_WR2) || (op == OP_WR1) || (op == OP_WR0);

  AST_STICKY_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    $past(sticky[STK_OVF]) |-> sticky[STK_OVF]);                            // R11
  AST_STICKY_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    stat[FLG_OVF] |-> sticky[STK_OVF]);                                    // R11
  AST_QUIET_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    quiet |=> ($stable(stat) && $stable(sticky)));                          // R12
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    holds_res |=> $stable(result));                                         // R12
  AST_SPARE_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat & ~16'h01C0) == '0) && ((sticky & ~16'h0040) == '0));            // R10
  AST_OVF_UNF_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(stat[FLG_OVF] && stat[FLG_UNF]));                                     // R10
  AST_CLEAR_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_CLR) |=> (stat == '0));                                       // R4
endmodule

bind mac80_unit mac80_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .op(op), .result(result), .stat(stat), .sticky(sticky)
);

// File: tb/tb_mac80_unit.sv
`timescale 1ns/1ps
module tb_mac80_unit;
  import mac_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  op;
  logic [31:0] opa, opb;
  logic [2:0]  fmt;
  logic        bank;
  logic [31:0] result;
  logic [15:0] stat, sticky;

  int n_chk = 0;
  int n_fail = 0;

  localparam logic signed [79:0] IMAX = 80'sh7FFFFFFF;
  localparam logic signed [79:0] IMIN = -80'sh80000000;
  localparam logic signed [79:0] FMAX = 80'sh7FFFFFFFFFFFFFFF;
  localparam logic signed [79:0] FMIN = -80'sh8000000000000000;

  logic signed [79:0] m_acc [2];
  logic [31:0] m_res;
  logic [15:0] m_stat, m_stk;

  logic [31:0] vals [8] = '{32'h0, 32'h1, 32'hFFFFFFFF, 32'h7FFFFFFF,
                            32'h80000000, 32'h3, 32'h12345678, 32'hFFFFFFFD};

  always #4 clk = ~clk;

  mac80_unit dut (.clk(clk), .rst_n(rst_n), .op(op), .opa(opa), .opb(opb),
                  .fmt(fmt), .bank(bank), .result(result), .stat(stat), .sticky(sticky));

  task automatic chk(input bit ok, input string tg, input logic [79:0] act, input logic [79:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tg, act, exp);
    end
  endtask

  task automatic do_op(input logic [3:0] o, input logic [31:0] a, input logic [31:0] b,
                       input logic [2:0] f, input logic bk, input string tg);
    logic signed [79:0] xa, xb, p, cur, nx, val;
    logic fl, v, u, rd;
    op = o; opa = a; opb = b; fmt = f; bank = bk;
    xa = {{48{f[0] & a[31]}}, a};
    xb = {{48{f[1] & b[31]}}, b};
    p  = xa * xb;
    if (f[2]) p = p <<< 1;
    cur = m_acc[bk]; nx = cur; fl = 1'b0; rd = 1'b0;
    case (o)
      OP_CLR:  begin nx = '0; fl = 1'b1; end
      OP_MUL:  begin nx = p; fl = 1'b1; end
      OP_MAC:  begin nx = cur + p; fl = 1'b1; end
      OP_MSB:  begin nx = cur - p; fl = 1'b1; end
      OP_MULR: begin fl = 1'b1; rd = 1'b1; m_res = f[2] ? p[63:32] : p[31:0]; end
      OP_SAT:  begin
        fl = 1'b1;
        if (f[2]) begin if (cur > FMAX) nx = FMAX; else if (cur < FMIN) nx = FMIN; end
        else      begin if (cur > IMAX) nx = IMAX; else if (cur < IMIN) nx = IMIN; end
      end
      OP_RND:  begin nx = (cur + 80'sh80000000) & ~80'shFFFFFFFF; fl = 1'b1; end
      OP_RD2:  begin rd = 1'b1; m_res = {{16{cur[79]}}, cur[79:64]}; end
      OP_RD1:  begin rd = 1'b1; m_res = cur[63:32]; end
      OP_RD0:  begin rd = 1'b1; m_res = cur[31:0]; end
      OP_RDR:  begin rd = 1'b1; m_res = f[2] ? cur[63:32] : cur[31:0]; end
      OP_WR2:  nx = {a[15:0], cur[63:0]};
      OP_WR1:  nx = {cur[79:64], a, cur[31:0]};
      OP_WR0:  nx = {cur[79:32], a};
      default: ;
    endcase
    val = (o == OP_MULR) ? p : nx;
    m_acc[bk] = nx;
    if (fl) begin
      v = f[2] ? (val > FMAX || val < FMIN) : (val > IMAX || val < IMIN);
      u = f[2] && (val != 0) && !v && (val <= IMAX) && (val >= IMIN);
      m_stat = '0;
      m_stat[6] = val[79]; m_stat[7] = v; m_stat[8] = u;
      if (v) m_stk[6] = 1'b1;
    end
    @(posedge clk);
    @(negedge clk);
    chk(result == m_res, rd ? tg : "R12 result hold", 80'(result), 80'(m_res));
    chk(stat == m_stat, fl ? "R10 status" : "R12 status hold", 80'(stat), 80'(m_stat));
    chk(sticky == m_stk, "R11 sticky", 80'(sticky), 80'(m_stk));
    op = OP_NOP;
  endtask

  task automatic reset_check();
    rst_n = 1'b0;
    #1;
    chk(result == 32'h0, "R1 result", 80'(result), 80'h0);
    chk(stat == 16'h0, "R1 stat", 80'(stat), 80'h0);
    chk(sticky == 16'h0, "R1 sticky", 80'(sticky), 80'h0);
    m_acc[0] = '0; m_acc[1] = '0; m_res = '0; m_stat = '0; m_stk = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    do_op(OP_RD1, 0, 0, 3'd0, 1'b0, "R1 acc0 cleared");
    do_op(OP_RD0, 0, 0, 3'd0, 1'b1, "R1 acc1 cleared");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    op = OP_NOP; opa = '0; opb = '0; fmt = '0; bank = 1'b0;
    @(negedge clk);
    reset_check();

    // R2 R3 R7: product sweep over operands and every format
    for (int f = 0; f < 8; f++)
      for (int i = 0; i < 8; i++)
        for (int j = 0; j < 8; j++) begin
          do_op(OP_MUL, vals[i], vals[j], 3'(f), 1'b0, "R2 mul");
          do_op(OP_RD0, 0, 0, 3'(f), 1'b0, "R2 low word");
          do_op(OP_RD1, 0, 0, 3'(f), 1'b0, f[2] ? "R3 frac high word" : "R2 high word");
          do_op(OP_RD2, 0, 0, 3'(f), 1'b0, "R6 guard read");
          do_op(OP_MULR, vals[j], vals[i], 3'(f), 1'b0, "R7 product to register");
          do_op(OP_RDR, 0, 0, 3'(f), 1'b0, "R3 format read");
        end

    // R4 R5: accumulate on background bank, foreground must stay put
    do_op(OP_CLR, 0, 0, 3'd0, 1'b1, "R4 clear");
    for (int f = 0; f < 8; f++)
      for (int i = 0; i < 8; i++) begin
        do_op(OP_MAC, vals[i], vals[7-i], 3'(f), 1'b1, "R4 mac");
        do_op(OP_MSB, vals[i], vals[(i+3)%8], 3'(f), 1'b1, "R4 msb");
        do_op(OP_MAC, vals[i], vals[i], 3'(f), 1'b1, "R4 mac");
        do_op(OP_RD2, 0, 0, 3'(f), 1'b1, "R4 acc guard");
        do_op(OP_RD1, 0, 0, 3'(f), 1'b1, "R4 acc high");
        do_op(OP_RD0, 0, 0, 3'(f), 1'b1, "R4 acc low");
      end
    do_op(OP_RD0, 0, 0, 3'd0, 1'b0, "R5 foreground untouched");
    do_op(OP_RD1, 0, 0, 3'd0, 1'b0, "R5 foreground untouched");
    do_op(OP_WR1, 32'hCAFEF00D, 0, 3'd0, 1'b1, "R5 write bg");
    do_op(OP_RD1, 0, 0, 3'd0, 1'b0, "R5 foreground untouched");
    do_op(OP_RD1, 0, 0, 3'd0, 1'b1, "R6 bg written");

    // R6 R8: build values with slice writes, then saturate
    for (int f = 0; f < 8; f += 4) begin
      do_op(OP_WR2, 32'hABCD0001, 0, 3'(f), 1'b0, "R6 wr2");
      do_op(OP_WR1, 32'h0, 0, 3'(f), 1'b0, "R6 wr1");
      do_op(OP_WR0, 32'h5, 0, 3'(f), 1'b0, "R6 wr0");
      do_op(OP_RD2, 0, 0, 3'(f), 1'b0, "R6 rd2 after write");
      do_op(OP_SAT, 0, 0, 3'(f), 1'b0, "R8 sat positive");
      do_op(OP_RD1, 0, 0, 3'(f), 1'b0, "R8 sat positive high");
      do_op(OP_RD0, 0, 0, 3'(f), 1'b0, "R8 sat positive low");
      do_op(OP_WR2, 32'h8000, 0, 3'(f), 1'b0, "R6 wr2");
      do_op(OP_SAT, 0, 0, 3'(f), 1'b0, "R8 sat negative");
      do_op(OP_RD2, 0, 0, 3'(f), 1'b0, "R8 sat negative guard");
      do_op(OP_RD1, 0, 0, 3'(f), 1'b0, "R8 sat negative high");
      do_op(OP_RD0, 0, 0, 3'(f), 1'b0, "R8 sat negative low");
      do_op(OP_WR2, 32'h0, 0, 3'(f), 1'b0, "R6 wr2");
      do_op(OP_WR1, 32'h0, 0, 3'(f), 1'b0, "R6 wr1");
      do_op(OP_WR0, 32'h12, 0, 3'(f), 1'b0, "R6 wr0");
      do_op(OP_SAT, 0, 0, 3'(f), 1'b0, "R8 in range");
      do_op(OP_RD0, 0, 0, 3'(f), 1'b0, "R8 in range unchanged");
    end

    // R9: rounding at the half point, below it, and with carry into guard
    do_op(OP_WR2, 32'h0, 0, 3'd4, 1'b0, "R6 wr2");
    do_op(OP_WR1, 32'h10, 0, 3'd4, 1'b0, "R6 wr1");
    do_op(OP_WR0, 32'h80000000, 0, 3'd4, 1'b0, "R6 wr0");
    do_op(OP_RND, 0, 0, 3'd4, 1'b0, "R9 round half");
    do_op(OP_RD1, 0, 0, 3'd4, 1'b0, "R9 round high");
    do_op(OP_RD0, 0, 0, 3'd4, 1'b0, "R9 round clears low");
    do_op(OP_WR0, 32'h7FFFFFFF, 0, 3'd4, 1'b0, "R6 wr0");
    do_op(OP_RND, 0, 0, 3'd4, 1'b0, "R9 round below half");
    do_op(OP_RD1, 0, 0, 3'd4, 1'b0, "R9 round no carry");
    do_op(OP_WR1, 32'hFFFFFFFF, 0, 3'd4, 1'b0, "R6 wr1");
    do_op(OP_WR0, 32'h80000000, 0, 3'd4, 1'b0, "R6 wr0");
    do_op(OP_RND, 0, 0, 3'd4, 1'b0, "R9 round carry");
    do_op(OP_RD2, 0, 0, 3'd4, 1'b0, "R9 round guard carry");
    do_op(OP_RD1, 0, 0, 3'd4, 1'b0, "R9 round high wraps");

    // R11 R12: sticky survives clean ops, quiet ops keep flags
    do_op(OP_MUL, 32'h80000000, 32'h80000000, 3'd7, 1'b0, "R11 frac overflow");
    do_op(OP_CLR, 0, 0, 3'd0, 1'b0, "R11 sticky after clear");
    do_op(OP_MUL, 32'h1, 32'h1, 3'd7, 1'b0, "R10 underflow");
    do_op(OP_NOP, 32'hFFFF, 32'hFFFF, 3'd7, 1'b0, "R12 nop");
    do_op(OP_WR0, 32'hFFFFFFFF, 0, 3'd0, 1'b0, "R12 write keeps flags");
    do_op(OP_RD0, 0, 0, 3'd0, 1'b0, "R12 read keeps flags");

    // R1: reset mid-run clears everything again
    reset_check();

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule